// File: doc/BRIEF.md
# Single-Bit Modify Unit

This unit carries out one bit-level change on a byte for a small 8-bit processor datapath. A command picks one of three actions: force the chosen bit high, force it low, or flip it. The bit position comes either from a 3-bit field in the command or from a byte held in a register. The byte being changed is one of three things: a register value supplied with the command, a byte in memory at the address held in a 16-bit pointer, or a byte in the top 256-byte page of memory picked by an 8-bit offset.

When the target is a register, the unit needs two states. It then returns the new byte together with a one-cycle write strobe for the register file. When the target is in memory, the unit reads the byte over a request/acknowledge bus, changes it, and writes it back to the same address. With a memory that answers at once, the whole sequence takes eight states. The unit never changes the processor flags: it hands back the flag word it received, unaltered. It accepts a new command only while idle.

Top module: `bitop_unit`

## Requirements
- R1: The action field selects the change to the target byte: 2'b00 sets the chosen bit to 1, 2'b01 clears it to 0, and 2'b10 or 2'b11 inverts it. All other bits keep their values.
- R2: When `idx_from_reg_i` is 0, the bit number is `idx_imm_i`. When it is 1, the bit number is the low 3 bits of `idx_reg_i`, and the upper 5 bits of that byte have no effect.
- R3: Address mode 2'b00 (register target) keeps `busy_o` high for exactly 2 cycles. `done_o` and `rd_we_o` are high only in the second of those cycles, `rd_wdata_o` carries the changed byte in that cycle, and `mem_req_o` stays low throughout.
- R4: Address mode 2'b01 (pointer target) reads the byte at `ptr_i` and writes the changed byte back to that same address. This is exactly one read and one write.
- R5: Address mode 2'b10 or 2'b11 (page target) uses the address 16'hFF00 plus `abs_i` for both the read and the write.
- R6: With a memory that acknowledges in the same cycle as the request, a memory-target command keeps `busy_o` high for exactly 8 cycles. The read is requested in busy cycle 2, the write in busy cycle 6, and `done_o` is high only in busy cycle 8.
- R7: Each cycle in which a memory request goes unacknowledged adds one cycle to the sequence. During that wait, `mem_req_o`, `mem_we_o` and `mem_addr_o` hold steady.
- R8: `flags_o` equals the `flags_i` value captured when the command was accepted. No command changes it.
- R9: `start_i` is ignored while `busy_o` is high. The running command's address, result and timing are unaffected, and no second command starts.
- R10: After reset, `busy_o`, `done_o`, `rd_we_o`, `mem_req_o` and `mem_we_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Command strobe, taken only while idle |
| op_i | input | 2 | Action: 00 set, 01 clear, 1x invert |
| idx_from_reg_i | input | 1 | 0: bit number from immediate, 1: from register byte |
| idx_imm_i | input | 3 | Immediate bit number |
| idx_reg_i | input | 8 | Register byte carrying the bit number |
| mode_i | input | 2 | 00 register, 01 pointer, 1x top page |
| reg_val_i | input | 8 | Register target value |
| ptr_i | input | 16 | Pointer address |
| abs_i | input | 8 | Offset into the top page |
| flags_i | input | 6 | Processor flag word |
| flags_o | output | 6 | Flag word handed back unchanged |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | Last state of the command |
| rd_we_o | output | 1 | Register write strobe |
| rd_wdata_o | output | 8 | Changed register byte |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | 16 | Memory address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data |
| mem_ack_i | input | 1 | Memory acknowledge |

## Verification
The bench runs every action code, every bit number, both index sources and every address mode, and it puts nonzero upper bits in the index register. A design that used those bits, or that swapped the clear and invert codes, would write the wrong byte. It counts busy cycles and records the cycle of each bus transfer, first with a zero-wait memory and then with waits added. An off-by-one in the step counter, or a request dropped during a wait, shows up as a wrong length or a missing transfer. It also pulses `start_i` in the middle of a memory command. A design that re-accepted the command would move the address or add a transfer.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
  typedef enum logic [1:0] {
    ACT_SET  = 2'b00,
    ACT_CLR  = 2'b01,
    ACT_INV  = 2'b10,
    ACT_INV2 = 2'b11
  } act_e;

  typedef enum logic [1:0] {
    TGT_REG  = 2'b00,
    TGT_PTR  = 2'b01,
    TGT_PAGE = 2'b10,
    TGT_PAG2 = 2'b11
  } tgt_e;

  function automatic logic tgt_is_mem(input logic [1:0] m);
    return m != TGT_REG;
  endfunction

  function automatic logic tgt_is_page(input logic [1:0] m);
    return m[1];
  endfunction
endpackage

// File: rtl/bitop_mask.sv
module bitop_mask #(
  parameter int DW = 8,
  localparam int IW = $clog2(DW)
) (
  input  logic [1:0]    op_i,
  input  logic [IW-1:0] idx_i,
  input  logic [DW-1:0] val_i,
  output logic [DW-1:0] mask_o,
  output logic [DW-1:0] res_o
);
  import bitop_pkg::*;

  function automatic logic [DW-1:0] one_hot(input logic [IW-1:0] i);
    logic [DW-1:0] m;
    m = '0;
    m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [DW-1:0] apply_act(input logic [1:0] op,
                                               input logic [DW-1:0] v,
                                               input logic [DW-1:0] m);
    if (op[1])            return v ^ m;
    else if (op[0])       return v & ~m;
    else                  return v | m;
  endfunction

  assign mask_o = one_hot(idx_i);
  assign res_o  = apply_act(op_i, val_i, mask_o);

  always_comb begin
    a_r1_mask_onehot: assert ($onehot(mask_o));
    a_r1_other_bits_kept: assert ($countones((res_o ^ val_i) & ~mask_o) == 0);
  end
endmodule

// File: rtl/bitop_seq.sv
module bitop_seq #(
  parameter int REG_STATES = 2,
  parameter int MEM_STATES = 8,
  parameter int RD_STEP    = 2,
  parameter int WR_STEP    = 6,
  localparam int CW = $clog2(MEM_STATES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic is_mem_i,
  input  logic ack_i,
  output logic accept_o,
  output logic busy_o,
  output logic rd_phase_o,
  output logic wr_phase_o,
  output logic done_o
);
  logic [CW-1:0] step_q;
  logic          busy_q;
  logic [CW-1:0] last_step;
  logic          stall;

  assign last_step  = is_mem_i ? CW'(MEM_STATES) : CW'(REG_STATES);
  assign accept_o   = start_i && !busy_q;
  assign busy_o     = busy_q;
  assign rd_phase_o = busy_q && is_mem_i && (step_q == CW'(RD_STEP));
  assign wr_phase_o = busy_q && is_mem_i && (step_q == CW'(WR_STEP));
  assign stall      = (rd_phase_o || wr_phase_o) && !ack_i;
  assign done_o     = busy_q && (step_q == last_step);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      step_q <= '0;
    end else if (accept_o) begin
      busy_q <= 1'b1;
      step_q <= CW'(1);
    end else if (busy_q) begin
      if (done_o) begin
        busy_q <= 1'b0;
        step_q <= '0;
      end else if (!stall) begin
        step_q <= step_q + CW'(1);
      end
    end
  end

  a_r3_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);
  a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o);
  a_r6_step_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (step_q != '0 && step_q <= CW'(MEM_STATES)));
  a_r7_stall_holds_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && stall) |=> $stable(step_q));
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit #(
  parameter int             DW         = 8,
  parameter int             AW         = 16,
  parameter int             FLAGW      = 6,
  parameter int             REG_STATES = 2,
  parameter int             MEM_STATES = 8,
  parameter logic [15:0]    PAGE_BASE  = 16'hFF00,
  localparam int            IW         = $clog2(DW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       op_i,
  input  logic             idx_from_reg_i,
  input  logic [IW-1:0]    idx_imm_i,
  input  logic [DW-1:0]    idx_reg_i,
  input  logic [1:0]       mode_i,
  input  logic [DW-1:0]    reg_val_i,
  input  logic [AW-1:0]    ptr_i,
  input  logic [DW-1:0]    abs_i,
  input  logic [FLAGW-1:0] flags_i,
  output logic [FLAGW-1:0] flags_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             rd_we_o,
  output logic [DW-1:0]    rd_wdata_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [DW-1:0]    mem_wdata_o,
  input  logic [DW-1:0]    mem_rdata_i,
  input  logic             mem_ack_i
);
  import bitop_pkg::*;

  logic             accept, rd_phase, wr_phase, rd_take;
  logic [1:0]       op_q;
  logic [IW-1:0]    idx_q;
  logic             is_mem_q;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    data_q;
  logic [FLAGW-1:0] flags_q;
  logic [DW-1:0]    mask, result;

  function automatic logic [IW-1:0] pick_index(input logic from_reg,
                                               input logic [IW-1:0] imm,
                                               input logic [DW-1:0] rb);
    return from_reg ? IW'(rb % DW) : imm;
  endfunction

  function automatic logic [AW-1:0] target_addr(input logic [1:0] m,
                                                input logic [AW-1:0] p,
                                                input logic [DW-1:0] a);
    return tgt_is_page(m) ? (AW'(PAGE_BASE) + AW'(a)) : p;
  endfunction

  bitop_seq #(
    .REG_STATES(REG_STATES),
    .MEM_STATES(MEM_STATES)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .is_mem_i  (is_mem_q),
    .ack_i     (mem_ack_i),
    .accept_o  (accept),
    .busy_o    (busy_o),
    .rd_phase_o(rd_phase),
    .wr_phase_o(wr_phase),
    .done_o    (done_o)
  );

  bitop_mask #(.DW(DW)) u_mask (
    .op_i  (op_q),
    .idx_i (idx_q),
    .val_i (data_q),
    .mask_o(mask),
    .res_o (result)
  );

  assign rd_take = rd_phase && mem_ack_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q     <= '0;
      idx_q    <= '0;
      is_mem_q <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
      flags_q  <= '0;
    end else if (accept) begin
      op_q     <= op_i;
      idx_q    <= pick_index(idx_from_reg_i, idx_imm_i, idx_reg_i);
      is_mem_q <= tgt_is_mem(mode_i);
      addr_q   <= target_addr(mode_i, ptr_i, abs_i);
      data_q   <= reg_val_i;
      flags_q  <= flags_i;
    end else if (rd_take) begin
      data_q   <= mem_rdata_i;
    end
  end

  assign flags_o     = flags_q;
  assign rd_we_o     = done_o && !is_mem_q;
  assign rd_wdata_o  = result;
  assign mem_req_o   = rd_phase || wr_phase;
  assign mem_we_o    = wr_phase;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = result;

  a_r3_reg_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !is_mem_q) |-> !mem_req_o);
  a_r7_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_we_o) && $stable(mem_addr_o)));
  a_r4_addr_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> $stable(mem_addr_o));
  a_r8_flags_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(flags_o));
  a_r9_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !done_o) |=> $stable(op_q));
endmodule

// File: tb/tb_bitop_unit.sv
module tb_bitop_unit;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [1:0] op_i = '0;
  logic       idx_from_reg_i = 1'b0;
  logic [2:0] idx_imm_i = '0;
  logic [7:0] idx_reg_i = '0;
  logic [1:0] mode_i = '0;
  logic [7:0] reg_val_i = '0;
  logic [15:0] ptr_i = '0;
  logic [7:0] abs_i = '0;
  logic [5:0] flags_i = '0;
  logic [5:0] flags_o;
  logic busy_o, done_o, rd_we_o, mem_req_o, mem_we_o;
  logic [7:0] rd_wdata_o, mem_wdata_o;
  logic [15:0] mem_addr_o;
  logic [7:0] mem_rdata_i = '0;
  logic       mem_ack_i = 1'b0;

  int checks = 0;
  int fails = 0;
  int wait_cfg = 0;
  int wait_left = 0;

  always #(CLK_P/2) clk = ~clk;

  bitop_unit dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .idx_from_reg_i(idx_from_reg_i), .idx_imm_i(idx_imm_i), .idx_reg_i(idx_reg_i),
    .mode_i(mode_i), .reg_val_i(reg_val_i), .ptr_i(ptr_i), .abs_i(abs_i),
    .flags_i(flags_i), .flags_o(flags_o), .busy_o(busy_o), .done_o(done_o),
    .rd_we_o(rd_we_o), .rd_wdata_o(rd_wdata_o), .mem_req_o(mem_req_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata_i), .mem_ack_i(mem_ack_i)
  );

  function automatic logic [7:0] mem_model(input logic [15:0] a);
    return 8'((a[7:0] * 5) ^ (a[15:8] * 3) ^ 8'hA5);
  endfunction

  always @(negedge clk) begin
    if (mem_req_o) begin
      mem_rdata_i = mem_model(mem_addr_o);
      if (wait_left > 0) begin
        mem_ack_i = 1'b0;
        wait_left = wait_left - 1;
      end else begin
        mem_ack_i = 1'b1;
      end
    end else begin
      mem_ack_i = 1'b0;
      wait_left = wait_cfg;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int expect_byte(input int op, input int v, input int b);
    int bitv;
    int w;
    bitv = (v / (2 ** b)) % 2;
    w = 2 ** b;
    if (op >= 2) return bitv ? v - w : v + w;
    if (op == 1) return bitv ? v - w : v;
    return bitv ? v : v + w;
  endfunction

  task automatic run_op(input int op, input int src, input int imm, input int rn,
                        input int mode, input int rv, input int ptr, input int ab,
                        input int fl, input int waits, input bit poke);
    int cyc, rcnt, wcnt, dcnt, wecnt, rcyc, wcyc, dcyc, rres, raddr, waddr, wdat;
    int bitn, addr, oper, exp_res, exp_len;
    bit is_mem;
    cyc = 0; rcnt = 0; wcnt = 0; dcnt = 0; wecnt = 0;
    rcyc = 0; wcyc = 0; dcyc = 0; rres = 0; raddr = 0; waddr = 0; wdat = 0;
    wait_cfg = waits;
    @(negedge clk); #1;
    op_i = 2'(op); idx_from_reg_i = 1'(src); idx_imm_i = 3'(imm); idx_reg_i = 8'(rn);
    mode_i = 2'(mode); reg_val_i = 8'(rv); ptr_i = 16'(ptr); abs_i = 8'(ab);
    flags_i = 6'(fl); start_i = 1'b1;
    @(negedge clk); #1;
    start_i = 1'b0;
    while (busy_o && cyc < 100) begin
      cyc++;
      if (poke && cyc == 2) begin
        start_i = 1'b1; op_i = ~op_i; mode_i = 2'b01; ptr_i = 16'h1234;
        idx_imm_i = ~idx_imm_i; flags_i = ~flags_i;
      end
      if (poke && cyc == 5) start_i = 1'b0;
      if (mem_req_o && mem_ack_i) begin
        if (mem_we_o) begin wcnt++; wcyc = cyc; waddr = int'(mem_addr_o); wdat = int'(mem_wdata_o); end
        else begin rcnt++; rcyc = cyc; raddr = int'(mem_addr_o); end
      end
      if (done_o) begin dcnt++; dcyc = cyc; end
      if (rd_we_o) begin wecnt++; rres = int'(rd_wdata_o); end
      @(negedge clk); #1;
    end
    start_i = 1'b0;
    bitn = src ? (rn % 8) : imm;
    is_mem = (mode != 0);
    addr = (mode >= 2) ? 65280 + ab : ptr;
    oper = is_mem ? int'(mem_model(16'(addr))) : rv;
    exp_res = expect_byte(op, oper, bitn);
    exp_len = is_mem ? 8 + 2 * waits : 2;
    chk(src ? "R2" : "R1", "result", is_mem ? wdat : rres, exp_res);
    chk(is_mem ? "R6" : "R3", "busy length", cyc, exp_len);
    chk(is_mem ? "R6" : "R3", "done count/cycle", dcnt * 1000 + dcyc, 1000 + exp_len);
    chk("R8", "flags", int'(flags_o), fl);
    if (is_mem) begin
      chk(mode >= 2 ? "R5" : "R4", "read addr", raddr, addr);
      chk(mode >= 2 ? "R5" : "R4", "write addr", waddr, addr);
      chk("R4", "transfer counts", rcnt * 10 + wcnt, 11);
      chk(waits > 0 ? "R7" : "R6", "read/write cycle", rcyc * 100 + wcyc,
          (2 + waits) * 100 + 6 + 2 * waits);
    end else begin
      chk("R3", "bus idle / strobe", rcnt * 100 + wcnt * 10 + wecnt, 1);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 3 + 2);
    chk("R10", "reset outputs", {busy_o, done_o, rd_we_o, mem_req_o, mem_we_o}, 0);
    rst_n = 1'b1;
    #(CLK_P * 2);
    chk("R10", "idle after reset", {busy_o, done_o, rd_we_o, mem_req_o, mem_we_o}, 0);
    for (int mode = 0; mode < 4; mode++)
      for (int src = 0; src < 2; src++)
        for (int op = 0; op < 4; op++)
          for (int b = 0; b < 8; b++)
            run_op(op, src, src ? 7 - b : b, src ? ((b * 41 + op * 8 + 8) % 256) : 255 - b,
                   mode, (b * 37 + op * 11 + mode) % 256, 4096 + b * 257 + op,
                   (b * 19 + op * 3) % 256, (b + op * 7 + mode) % 64, 0, 1'b0);
    run_op(2, 0, 3, 0, 1, 0, 16'h0456, 0, 6'h2A, 1, 1'b0);
    run_op(0, 1, 0, 8'hFD, 2, 0, 0, 8'h7E, 6'h15, 3, 1'b0);
    run_op(1, 0, 6, 0, 1, 0, 16'h8001, 0, 6'h3F, 2, 1'b0);
    run_op(0, 0, 5, 0, 2, 0, 0, 8'h42, 6'h09, 0, 1'b1);
    run_op(2, 1, 0, 8'hE1, 1, 0, 16'hBEEF, 0, 6'h30, 1, 1'b1);
    #(CLK_P * 3);
    chk("R9", "no second command after poke", {busy_o, mem_req_o}, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule